// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two request lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Both lines look at the same raw level vector. Each line has its own enable mask, and each output is high when at least one raw level bit is high and enabled for that line. No source is latched. A source that drops its level removes its request.

Software reaches the block through a small word-addressed register port. Reads are combinational and return data in the same cycle. Writes take effect at the next rising clock edge. Each enable mask can only be changed bit by bit through a set word and a clear word, so two agents can adjust different bits without a read-modify-write race. Source bit 0 can also be asserted by software through a private flag. That flag is ORed into the raw level, which gives a software-generated interrupt on the lowest line. Both request outputs are registered.

Top module: `dual_lvl_intc`

## Requirements
- R1: A read of word 1 or word 9 returns the raw level vector. Bits 31..1 equal `src_lvl` in the same cycle.
- R2: `irq_o` is high in cycle n+1 exactly when (raw level AND normal enable mask) is non-zero in cycle n.
- R3: `fiq_o` is high in cycle n+1 exactly when (raw level AND fast enable mask) is non-zero in cycle n.
- R4: A write to word 2 ORs the write data into the normal mask. A write to word 10 does the same for the fast mask. A read of word 2 or word 10 returns that mask.
- R5: A write to word 3 clears every normal-mask bit written as one. A write to word 11 does the same for the fast mask. All other mask bits keep their value.
- R6: A write to word 4 with data bit 0 = 1 sets the software flag. A write to word 5 with data bit 0 = 1 clears it. Data bits 31..1 of either write have no effect. A read of word 4 returns the flag in bit 0 and zeros above it.
- R7: Raw level bit 0 is the OR of `src_lvl[0]` and the software flag.
- R8: A read of word 0 returns raw level AND normal mask. A read of word 8 returns raw level AND fast mask.
- R9: Reads of words 3, 5 and 11, and of unmapped words (6, 7, 12 to 15), return zero. Writes to words 0, 1, 8 and 9 change neither mask nor the software flag.
- R10: After reset, both masks, the software flag, `irq_o` and `fiq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 32 | Interrupt source levels, one bit per source |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
Two things can happen at the same clock edge: a mask write and a change on the source pins. The bench forces this on purpose. In one case it raises a source bit in the same cycle that a write to word 3 removes that bit from the normal mask. In another case it raises a source bit in the same cycle that a write to word 10 enables it on the fast line. Both outputs sample the pre-edge mask together with the pre-edge level, so the expected result is derived from the settled pair one cycle later. The normal line must stay low, and the fast line must rise exactly one cycle after the mask is updated.

// File: rtl/dli_pkg.sv
`timescale 1ns/1ps
package dli_pkg;
  localparam int DLI_NSRC = 32;
  localparam int DLI_DW   = 32;
  localparam int DLI_AW   = 4;

  // Word codes: software decodes these positions, so they are fixed.
  typedef enum logic [DLI_AW-1:0] {
    W_IRQ_STAT = 4'd0,
    W_RAW_A    = 4'd1,
    W_IRQ_ENS  = 4'd2,
    W_IRQ_ENC  = 4'd3,
    W_SW_SET   = 4'd4,
    W_SW_CLR   = 4'd5,
    W_FIQ_STAT = 4'd8,
    W_RAW_B    = 4'd9,
    W_FIQ_ENS  = 4'd10,
    W_FIQ_ENC  = 4'd11
  } word_e;

  localparam int LANES = 2;  // lane 0 = normal, lane 1 = fast

  function automatic logic is_status_word(input logic [DLI_AW-1:0] a);
    return (a == W_IRQ_STAT) || (a == W_RAW_A) || (a == W_FIQ_STAT) || (a == W_RAW_B);
  endfunction
endpackage

// File: rtl/dli_enable_reg.sv
`timescale 1ns/1ps
module dli_enable_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (set_stb) mask <= mask | bits;
    else if (clr_stb) mask <= mask & ~bits;
  end
endmodule

// File: rtl/dli_soft_flag.sv
`timescale 1ns/1ps
module dli_soft_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic bit0,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (set_stb && bit0)  flag <= 1'b1;
    else if (clr_stb && bit0)  flag <= 1'b0;
  end
endmodule

// File: rtl/dli_read_mux.sv
`timescale 1ns/1ps
module dli_read_mux
  import dli_pkg::*;
#(
  parameter int NSRC = DLI_NSRC,
  parameter int DW   = DLI_DW
) (
  input  logic [DLI_AW-1:0] addr,
  input  logic [NSRC-1:0]   raw_lvl,
  input  logic [NSRC-1:0]   irq_pend,
  input  logic [NSRC-1:0]   fiq_pend,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic [NSRC-1:0]   fiq_mask,
  input  logic              soft_flag,
  output logic [DW-1:0]     rdata
);
  function automatic logic [DW-1:0] widen(input logic [NSRC-1:0] v);
    return DW'(v);
  endfunction

  always_comb begin
    case (addr)
      W_IRQ_STAT:         rdata = widen(irq_pend);
      W_FIQ_STAT:         rdata = widen(fiq_pend);
      W_RAW_A, W_RAW_B:   rdata = widen(raw_lvl);
      W_IRQ_ENS:          rdata = widen(irq_mask);
      W_FIQ_ENS:          rdata = widen(fiq_mask);
      W_SW_SET:           rdata = DW'(soft_flag);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_lvl_intc.sv
`timescale 1ns/1ps
module dual_lvl_intc
  import dli_pkg::*;
#(
  parameter int NSRC = DLI_NSRC,
  parameter int DW   = DLI_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic [DLI_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  function automatic logic [NSRC-1:0] f_gate(input logic [NSRC-1:0] l, input logic [NSRC-1:0] m);
    return l & m;
  endfunction

  function automatic logic f_any(input logic [NSRC-1:0] v);
    return |v;
  endfunction

  // Write decode, named for the checker
  logic [LANES-1:0] en_set_stb, en_clr_stb;
  logic             sw_set_stb, sw_clr_stb;
  logic             bad_wr;
  logic [NSRC-1:0]  wbits;

  assign wbits         = bus_wdata[NSRC-1:0];
  assign en_set_stb[0] = bus_we && (bus_addr == W_IRQ_ENS);
  assign en_clr_stb[0] = bus_we && (bus_addr == W_IRQ_ENC);
  assign en_set_stb[1] = bus_we && (bus_addr == W_FIQ_ENS);
  assign en_clr_stb[1] = bus_we && (bus_addr == W_FIQ_ENC);
  assign sw_set_stb    = bus_we && (bus_addr == W_SW_SET);
  assign sw_clr_stb    = bus_we && (bus_addr == W_SW_CLR);
  assign bad_wr        = bus_we && is_status_word(bus_addr);

  logic [NSRC-1:0] lane_mask [LANES];
  logic [NSRC-1:0] lane_pend [LANES];
  logic [LANES-1:0] lane_req_q;

  logic            soft_flag;
  logic [NSRC-1:0] raw_lvl;

  dli_soft_flag u_soft (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (sw_set_stb),
    .clr_stb (sw_clr_stb),
    .bit0    (bus_wdata[0]),
    .flag    (soft_flag)
  );

  assign raw_lvl = src_lvl | NSRC'(soft_flag);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dli_enable_reg #(.W(NSRC)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (en_set_stb[g]),
      .clr_stb (en_clr_stb[g]),
      .bits    (wbits),
      .mask    (lane_mask[g])
    );

    assign lane_pend[g] = f_gate(raw_lvl, lane_mask[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_req_q[g] <= 1'b0;
      else        lane_req_q[g] <= f_any(lane_pend[g]);
    end
  end

  logic [NSRC-1:0] irq_mask, fiq_mask, irq_pend, fiq_pend;
  assign irq_mask = lane_mask[0];
  assign fiq_mask = lane_mask[1];
  assign irq_pend = lane_pend[0];
  assign fiq_pend = lane_pend[1];
  assign irq_o    = lane_req_q[0];
  assign fiq_o    = lane_req_q[1];

  dli_read_mux #(.NSRC(NSRC), .DW(DW)) u_rd (
    .addr      (bus_addr),
    .raw_lvl   (raw_lvl),
    .irq_pend  (irq_pend),
    .fiq_pend  (fiq_pend),
    .irq_mask  (irq_mask),
    .fiq_mask  (fiq_mask),
    .soft_flag (soft_flag),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/dli_checker.sv
`timescale 1ns/1ps
module dli_checker
  import dli_pkg::*;
#(
  parameter int NSRC = DLI_NSRC,
  parameter int DW   = DLI_DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_lvl,
  input logic [DLI_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NSRC-1:0]   irq_mask,
  input logic [NSRC-1:0]   fiq_mask,
  input logic [NSRC-1:0]   irq_pend,
  input logic [NSRC-1:0]   fiq_pend,
  input logic [NSRC-1:0]   raw_lvl,
  input logic              soft_flag,
  input logic              bad_wr,
  input logic              irq_o,
  input logic              fiq_o
);
  logic [NSRC-1:0] wd;
  assign wd = bus_wdata[NSRC-1:0];

  AST_RAW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == W_RAW_A) |-> (bus_rdata[NSRC-1:1] == src_lvl[NSRC-1:1])); // R1
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pend) |=> irq_o); // R2
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_pend) |=> !irq_o); // R2
  AST_FIQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|fiq_pend) |=> fiq_o); // R3
  AST_FIQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fiq_pend) |=> !fiq_o); // R3
  AST_IRQ_ENSET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_IRQ_ENS) |=> ((irq_mask & $past(wd)) == $past(wd))); // R4
  AST_FIQ_ENSET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_FIQ_ENS) |=> ((fiq_mask & $past(wd)) == $past(wd))); // R4
  AST_IRQ_ENCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_IRQ_ENC) |=> ((irq_mask & $past(wd)) == '0)); // R5
  AST_FIQ_ENCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_FIQ_ENC) |=> ((fiq_mask & $past(wd)) == '0)); // R5
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_SW_SET && bus_wdata[0]) |=> soft_flag); // R6
  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == W_SW_CLR && bus_wdata[0]) |=> !soft_flag); // R6
  AST_SOFT_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_flag |-> raw_lvl[0]); // R7
  AST_IRQ_STAT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == W_IRQ_STAT) |-> ((bus_rdata[NSRC-1:0] & ~irq_mask) == '0)); // R8
  AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == W_IRQ_ENC || bus_addr == W_SW_CLR || bus_addr == W_FIQ_ENC) |-> (bus_rdata == '0)); // R9
  AST_BAD_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(soft_flag))); // R9
endmodule

bind dual_lvl_intc dli_checker #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_lvl   (src_lvl),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_mask  (irq_mask),
  .fiq_mask  (fiq_mask),
  .irq_pend  (irq_pend),
  .fiq_pend  (fiq_pend),
  .raw_lvl   (raw_lvl),
  .soft_flag (soft_flag),
  .bad_wr    (bad_wr),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/sim_dual_lvl_intc.sv
`timescale 1ns/1ps
module sim_dual_lvl_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  always #10 clk = ~clk;  // 50 MHz

  dual_lvl_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 irq line, 2 fiq line
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int tests = 0, fails = 0;
  bit done = 0;

  // Reference model, kept from the requirements
  logic [31:0] m_ien = '0, m_fen = '0, m_src = '0;
  logic        m_soft = 1'b0;

  function automatic logic [31:0] m_raw();
    return m_src | {31'b0, m_soft};
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd2:  m_ien = m_ien | d;
      4'd3:  m_ien = m_ien & ~d;
      4'd10: m_fen = m_fen | d;
      4'd11: m_fen = m_fen & ~d;
      4'd4:  if (d[0]) m_soft = 1'b1;
      4'd5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_src(input logic [3:0] a, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; src_lvl = s;
    model_wr(a, d); m_src = s;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk);
    src_lvl = s; m_src = s;
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    sb.push_back('{0, e, tag});
  endtask

  task automatic exp_out(input string tag);
    @(negedge clk);
    sb.push_back('{1, {31'b0, |(m_raw() & m_ien)}, {tag, " irq_o"}});
    sb.push_back('{2, {31'b0, |(m_raw() & m_fen)}, {tag, " fiq_o"}});
  endtask

  // Monitor: pops expected items and compares mid low phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq_o} : {31'b0, fiq_o};
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    exp_rd(4'd2, 32'h0, "R10 normal mask after reset");
    exp_rd(4'd10, 32'h0, "R10 fast mask after reset");
    exp_rd(4'd4, 32'h0, "R10 soft flag after reset");
    exp_out("R10 outputs after reset");

    // R1 raw level on both aliases
    set_src(32'hA500_0010);
    exp_rd(4'd1, m_raw(), "R1 raw via word 1");
    exp_rd(4'd9, m_raw(), "R1 raw via word 9");

    // R4 set accumulates, R8 masked status, R2 output
    wr(4'd2, 32'h0000_0010);
    exp_rd(4'd2, m_ien, "R4 normal mask set");
    wr(4'd2, 32'h0000_0100);
    exp_rd(4'd2, m_ien, "R4 normal mask OR accumulate");
    exp_rd(4'd0, m_raw() & m_ien, "R8 normal status");
    exp_out("R2 normal line from enabled source");

    wr(4'd10, 32'hA000_0000);
    exp_out("R3 fast line from enabled source");
    exp_rd(4'd8, m_raw() & m_fen, "R8 fast status");
    exp_rd(4'd10, m_fen, "R4 fast mask set");

    // R5 clear
    wr(4'd3, 32'h0000_0010);
    exp_rd(4'd2, m_ien, "R5 normal mask clear");
    exp_out("R5 R2 line drops after clear");

    // R6 / R7 software flag
    wr(4'd4, 32'hFFFF_FFFE);
    exp_rd(4'd4, m_soft, "R6 upper bits of set ignored");
    wr(4'd4, 32'h0000_0001);
    exp_rd(4'd4, m_soft, "R6 soft flag set");
    exp_rd(4'd1, m_raw(), "R7 soft flag merged into raw bit 0");
    wr(4'd2, 32'h0000_0001);
    exp_out("R2 R7 normal line from soft flag");
    wr(4'd5, 32'hFFFF_FFFE);
    exp_rd(4'd4, m_soft, "R6 upper bits of clear ignored");
    wr(4'd5, 32'h0000_0001);
    exp_rd(4'd4, m_soft, "R6 soft flag clear");
    exp_out("R2 R6 line drops after soft clear");

    set_src(32'hA500_0011);
    exp_rd(4'd1, m_raw(), "R7 external bit 0 alone");
    exp_out("R7 R2 external bit 0 requests");
    set_src(32'hA500_0010);

    // R9 invalid reads
    foreach (sb[i]) ;
    exp_rd(4'd3, 32'h0, "R9 read of word 3");
    exp_rd(4'd5, 32'h0, "R9 read of word 5");
    exp_rd(4'd11, 32'h0, "R9 read of word 11");
    exp_rd(4'd6, 32'h0, "R9 read of unmapped word 6");
    exp_rd(4'd15, 32'h0, "R9 read of unmapped word 15");

    // R9 invalid writes
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    exp_rd(4'd2, m_ien, "R9 normal mask untouched by status writes");
    exp_rd(4'd10, m_fen, "R9 fast mask untouched by status writes");
    exp_rd(4'd4, m_soft, "R9 soft flag untouched by status writes");

    // Same-cycle: mask clear while source rises
    wr_src(4'd3, 32'h0000_0100, 32'hA500_0110);
    exp_out("R2 R5 clear and rise in same cycle");
    wr(4'd11, 32'hFFFF_FFFF);
    exp_out("R3 R5 fast line drops after full clear");
    wr_src(4'd10, 32'h0000_0200, 32'hA500_0310);
    exp_out("R3 R4 enable and rise in same cycle");

    // Levels fall: both lines follow
    set_src(32'h0);
    exp_out("R2 R3 lines follow falling level");

    @(negedge clk);
    #8;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule